// File: doc/BRIEF.md
# Raster Horizontal Blanking and Sync Generator

This block produces the horizontal blanking and horizontal sync strobes for a display controller that counts in character clocks. One clock of `clk` is one character clock. A line counter steps from zero up to a programmed last value and then returns to zero. Blanking and sync each turn on when the counter equals a start value that uses the full counter width.

Each strobe turns off when the low bits of the counter match a short end code. The end code is therefore the low bits of (start + length). For blanking, the end code is six bits wide in standard mode and eight bits wide in extended mode. For sync, the end code is five bits wide. Both edges of the sync pulse can be held back together by zero to three character clocks, to cover pipeline latency elsewhere in the display path.

The register values arrive as plain parallel inputs. A packed sync-control byte carries three things: the sync end code, the sync delay code and one bit of the blanking end code.

Top module: `htiming_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the edge leaves `hcount` at 0 and both `hblank` and `hsync` at 0.
- R2: If `hcount` equals `h_total`, it becomes 0 at the next edge. Otherwise it increments by one at the next edge, modulo 2^CNT_W.
- R3: When blanking is off and `hcount` equals `blank_start` in cycle k, `hblank` is high from cycle k+2.
- R4: In standard mode (`ext_mode`=0), the blanking end code is 6 bits: {`sync_ctl[7]`, `blank_end_lo[4:0]`}. Take the first cycle j after blanking started in which `hcount[5:0]` equals this code. `hblank` is low from cycle j+2.
- R5: In extended mode (`ext_mode`=1), the blanking end code is 8 bits: {`blank_end_hi[1:0]`, `sync_ctl[7]`, `blank_end_lo[4:0]`}. It is compared against `hcount[7:0]`, with the same timing as R4.
- R6: The undelayed sync turns on in the cycle after `hcount` equals `sync_start`. It turns off in the cycle after the first later cycle in which `hcount[4:0]` equals `sync_ctl[4:0]`.
- R7: `sync_ctl[6:5]` gives the sync delay d: 00 is 0, 01 is 1, 10 is 2 and 11 is 3 character clocks. Both edges of `hsync` follow the undelayed sync by d+1 cycles.
- R8: An active blanking or sync interval continues through the counter's return to zero. It ends only on its end-code match.
- R9: A change of `sync_ctl[6:5]` selects the new delay at the very next edge. The history of the undelayed sync is kept across the change.
- R10: A blanking end-code match in the same cycle that blanking starts is ignored. Blanking stays on until the next match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous reset, active high |
| h_total | input | CNT_W | Last counter value before the counter returns to zero |
| blank_start | input | CNT_W | Counter value that starts blanking |
| blank_end_lo | input | 5 | Low five bits of the blanking end code |
| blank_end_hi | input | 2 | Bits 7:6 of the blanking end code, used in extended mode |
| ext_mode | input | 1 | 1 selects the 8-bit blanking end code, 0 selects the 6-bit code |
| sync_start | input | CNT_W | Counter value that starts sync |
| sync_ctl | input | 8 | [7] blanking end bit 5, [6:5] sync delay, [4:0] sync end code |
| hcount | output | CNT_W | Registered character counter |
| hblank | output | 1 | Registered horizontal blanking strobe |
| hsync | output | 1 | Registered, delayed horizontal sync strobe |

## Verification
Each result has a fixed lag after the `hcount` value that causes it:
- `hcount` itself changes one edge after the cycle it is computed from.
- The internal blanking and sync states change one edge after a start or end match.
- `hblank` follows two edges after the cycle in which `hcount` matched.
- `hsync` follows 2+d edges after that cycle, where d is the sync delay.

The bench keeps its own model with one register per stage in the requirements. At each falling edge it first advances the model by one step from the inputs that the coming rising edge will see. It then compares all three outputs at the following falling edge. As a result, each comparison lands in the exact cycle the requirement names.

// File: rtl/htiming_pkg.sv
package htiming_pkg;

  localparam int BEND_W   = 8;  // widest blanking end code
  localparam int SEND_W   = 5;  // sync end code width
  localparam int DLY_W    = 2;  // sync delay code width

  // Bits of the blanking end code that take part in the compare.
  function automatic logic [BEND_W-1:0] blank_end_mask(input logic ext);
    return ext ? 8'hFF : 8'h3F;
  endfunction

endpackage

// File: rtl/htiming_counter.sv
module htiming_counter #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] total,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (cnt == total) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/htiming_window.sv
// Start on a full-width match, stop on a masked low-bit match seen
// only while the window is already open.
module htiming_window #(
  parameter int CNT_W = 9,
  parameter int END_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] start,
  input  logic [END_W-1:0] end_val,
  input  logic [END_W-1:0] end_mask,
  output logic             active
);

  logic end_hit;

  assign end_hit = (((cnt[END_W-1:0] ^ end_val) & end_mask) == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
    end else if (active) begin
      if (end_hit) active <= 1'b0;
    end else if (cnt == start) begin
      active <= 1'b1;
    end
  end

endmodule

// File: rtl/htiming_delay.sv
// Shift line with a selectable tap; the output is registered.
module htiming_delay #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  output logic             dout
);

  localparam int NTAP   = 1 << SEL_W;
  localparam int STAGES = NTAP - 1;

  logic [STAGES-1:0] pipe;
  logic [NTAP-1:0]   taps;

  always_comb begin
    taps[0] = din;
    for (int i = 1; i < NTAP; i++) taps[i] = pipe[i-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '0;
      dout <= 1'b0;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      dout <= taps[sel];
    end
  end

endmodule

// File: rtl/htiming_gen.sv
module htiming_gen #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] h_total,
  input  logic [CNT_W-1:0] blank_start,
  input  logic [4:0]       blank_end_lo,
  input  logic [1:0]       blank_end_hi,
  input  logic             ext_mode,
  input  logic [CNT_W-1:0] sync_start,
  input  logic [7:0]       sync_ctl,
  output logic [CNT_W-1:0] hcount,
  output logic             hblank,
  output logic             hsync
);

  import htiming_pkg::*;

  logic [BEND_W-1:0] blank_end_val;
  logic [BEND_W-1:0] blank_mask;
  logic              blank_raw;
  logic              sync_raw;

  assign blank_end_val = {blank_end_hi, sync_ctl[7], blank_end_lo};
  assign blank_mask    = blank_end_mask(ext_mode);

  htiming_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .total (h_total),
    .cnt   (hcount)
  );

  htiming_window #(.CNT_W(CNT_W), .END_W(BEND_W)) u_blank (
    .clk      (clk),
    .rst      (rst),
    .cnt      (hcount),
    .start    (blank_start),
    .end_val  (blank_end_val),
    .end_mask (blank_mask),
    .active   (blank_raw)
  );

  htiming_window #(.CNT_W(CNT_W), .END_W(SEND_W)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .cnt      (hcount),
    .start    (sync_start),
    .end_val  (sync_ctl[4:0]),
    .end_mask ({SEND_W{1'b1}}),
    .active   (sync_raw)
  );

  htiming_delay #(.SEL_W(DLY_W)) u_dly (
    .clk  (clk),
    .rst  (rst),
    .din  (sync_raw),
    .sel  (sync_ctl[6:5]),
    .dout (hsync)
  );

  // Matches the one register in the sync tap path.
  always_ff @(posedge clk) begin
    if (rst) hblank <= 1'b0;
    else     hblank <= blank_raw;
  end

endmodule

// File: rtl/htiming_chk.sv
module htiming_chk #(
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] hcount,
  input logic [CNT_W-1:0] h_total,
  input logic [CNT_W-1:0] blank_start,
  input logic [CNT_W-1:0] sync_start,
  input logic [1:0]       dly,
  input logic             blank_raw,
  input logic             sync_raw,
  input logic             hblank,
  input logic             hsync
);

  logic [2:0] since_rst;
  logic       warm;

  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 1'b1;
  end
  assign warm = (since_rst >= 3'd5);

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (hcount == '0 && !hblank && !hsync));

  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    (hcount == h_total) |=> (hcount == '0));

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (hcount != h_total) |=> ((hcount - $past(hcount)) == {{(CNT_W-1){1'b0}}, 1'b1}));

  a_r3_blank_set: assert property (@(posedge clk) disable iff (rst)
    (!blank_raw && hcount == blank_start) |=> blank_raw);

  a_r6_sync_set: assert property (@(posedge clk) disable iff (rst)
    (!sync_raw && hcount == sync_start) |=> sync_raw);

  a_r7_delay0: assert property (@(posedge clk) disable iff (rst)
    (warm && dly == 2'd0) |=> (hsync == $past(sync_raw)));

  a_r7_delay1: assert property (@(posedge clk) disable iff (rst)
    (warm && dly == 2'd1) |=> (hsync == $past(sync_raw, 2)));

  a_r7_delay2: assert property (@(posedge clk) disable iff (rst)
    (warm && dly == 2'd2) |=> (hsync == $past(sync_raw, 3)));

  a_r7_delay3: assert property (@(posedge clk) disable iff (rst)
    (warm && dly == 2'd3) |=> (hsync == $past(sync_raw, 4)));

endmodule

bind htiming_gen htiming_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .hcount      (hcount),
  .h_total     (h_total),
  .blank_start (blank_start),
  .sync_start  (sync_start),
  .dly         (sync_ctl[6:5]),
  .blank_raw   (blank_raw),
  .sync_raw    (sync_raw),
  .hblank      (hblank),
  .hsync       (hsync)
);

// File: tb/htiming_gen_bench.sv
module htiming_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 9;
  localparam int CMOD       = 1 << CNT_W;

  logic             clk = 1'b0;
  logic             rst;
  logic [CNT_W-1:0] h_total, blank_start, sync_start;
  logic [4:0]       blank_end_lo;
  logic [1:0]       blank_end_hi;
  logic             ext_mode;
  logic [7:0]       sync_ctl;
  logic [CNT_W-1:0] hcount;
  logic             hblank, hsync;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // reference model state
  int m_cnt = 0;
  bit m_braw = 0, m_sraw = 0, m_hb = 0, m_hs = 0;
  bit [2:0] m_d = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  htiming_gen #(.CNT_W(CNT_W)) u_htiming_gen (
    .clk(clk), .rst(rst), .h_total(h_total), .blank_start(blank_start),
    .blank_end_lo(blank_end_lo), .blank_end_hi(blank_end_hi), .ext_mode(ext_mode),
    .sync_start(sync_start), .sync_ctl(sync_ctl),
    .hcount(hcount), .hblank(hblank), .hsync(hsync)
  );

  function automatic bit sync_tap(input int d, input bit s, input bit [2:0] p);
    return (d == 0) ? s : p[d-1];
  endfunction

  task automatic check(input string tag, input int act, input int exp, input string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // One character clock: advance the model from the inputs the edge sees,
  // then compare at the following falling edge.
  task automatic tick(input string btag, input string stag);
    int bend, bmask, dly;
    bit n_braw, n_sraw;
    if (rst) begin
      m_cnt = 0; m_braw = 0; m_sraw = 0; m_hb = 0; m_hs = 0; m_d = '0;
    end else begin
      bend  = {blank_end_hi, sync_ctl[7], blank_end_lo};
      bmask = ext_mode ? 255 : 63;  // R4 / R5 code width
      dly   = int'(sync_ctl[6:5]);
      m_hb  = m_braw;
      m_hs  = sync_tap(dly, m_sraw, m_d);
      m_d   = {m_d[1:0], m_sraw};
      n_braw = m_braw ? ((m_cnt & bmask) != (bend & bmask)) : (m_cnt == int'(blank_start));
      n_sraw = m_sraw ? ((m_cnt & 31) != int'(sync_ctl[4:0])) : (m_cnt == int'(sync_start));
      m_braw = n_braw;
      m_sraw = n_sraw;
      m_cnt  = (m_cnt == int'(h_total)) ? 0 : (m_cnt + 1) % CMOD;
    end
    @(negedge clk);
    check(rst ? "R1" : "R2", int'(hcount), m_cnt, "hcount");
    check(rst ? "R1" : btag, int'(hblank), int'(m_hb), "hblank");
    check(rst ? "R1" : stag, int'(hsync), int'(m_hs), "hsync");
  endtask

  task automatic set_bend(input int v);
    blank_end_lo = v[4:0];
    sync_ctl[7]  = v[5];
    blank_end_hi = v[7:6];
  endtask

  task automatic set_sync(input int start, input int width, input int dly);
    sync_start    = CNT_W'(start);
    sync_ctl[4:0] = 5'((start + width) & 31);
    sync_ctl[6:5] = 2'(dly);
  endtask

  task automatic run(input int n, input string btag, input string stag);
    for (int i = 0; i < n; i++) tick(btag, stag);
  endtask

  initial begin
    int seed;
    seed = 32'h5EED_0071;
    void'($urandom(seed));
    rst = 1'b1;
    h_total = 9'd99; blank_start = 9'd80; ext_mode = 1'b0;
    sync_ctl = '0; blank_end_lo = '0; blank_end_hi = '0; sync_start = 9'd84;
    @(negedge clk);
    run(3, "R1", "R1");                      // R1 reset state
    rst = 1'b0;

    // R4 standard 6-bit end: 80 + 18 = 98, low six bits 34
    set_bend(34); set_sync(84, 10, 0);
    run(250, "R4", "R6");

    // R5 extended 8-bit end: 200 + 90 = 290, low eight bits 34
    h_total = 9'd299; blank_start = 9'd200; ext_mode = 1'b1;
    set_bend(34); set_sync(220, 20, 0);
    run(700, "R5", "R6");

    // R7 each delay code
    ext_mode = 1'b0; h_total = 9'd79; blank_start = 9'd60; set_bend((60 + 12) & 63);
    for (int d = 0; d < 4; d++) begin
      set_sync(64, 7, d);
      run(240, "R4", "R7");
    end

    // R8 intervals spanning the wrap
    h_total = 9'd63; blank_start = 9'd60; set_bend((60 + 10) & 63);
    set_sync(62, 5, 1);
    run(200, "R8", "R8");

    // R10 end code equal to the start's low bits
    h_total = 9'd99; blank_start = 9'd40; set_bend(40);
    set_sync(10, 4, 0);
    run(300, "R10", "R6");

    // R9 delay changes while the sync pulse is in flight
    h_total = 9'd49; blank_start = 9'd5; set_bend(25);
    set_sync(20, 12, 0);
    for (int i = 0; i < 60; i++) begin
      sync_ctl[6:5] = 2'($urandom_range(0, 3));
      run(5, "R3", "R9");
    end

    // random line shapes in both modes
    for (int k = 0; k < 20; k++) begin
      int tot, bs, ss;
      tot = $urandom_range(40, 450);
      bs  = $urandom_range(0, tot);
      ss  = $urandom_range(0, tot);
      h_total = CNT_W'(tot); blank_start = CNT_W'(bs);
      ext_mode = 1'($urandom_range(0, 1));
      set_bend((bs + $urandom_range(1, 60)) & 255);
      set_sync(ss, $urandom_range(1, 31), $urandom_range(0, 3));
      run(300, ext_mode ? "R5" : "R3", "R7");
    end

    // R1 again: reset mid-line
    rst = 1'b1;
    run(2, "R1", "R1");
    rst = 1'b0;
    run(20, "R3", "R6");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all) actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule